// File: doc/BRIEF.md
# Horizontal Character Position Timing Counter

This block splits every horizontal scan line of a character display into character times. It is clocked once per character time and holds two cascaded 4-bit counters: a subgroup counter that steps on every clock, and a group counter that steps each time the subgroup counter wraps. Both counters start each line at 3. The line ends on a combined decode of the two counters, so its length is 102 character times: 13 + 16 + 16 + 16 + 16 + 16 + 9.

Several outputs come straight from the counter state. Group bit 2 marks the display part of the line. Group bit 3 is the advance signal from which horizontal sync is built. The four subgroup bits, with the two low group bits above them, form a six-bit column address for the display RAM. A one-cycle end-of-line pulse steps the vertical (scan line) counters.

Top module: `hchar_timing`

## Requirements
- R1: While `rst` is high at a rising clock edge, both counters load 3. After that edge `col_addr` is 51 (0x33), and `hdisp`, `hsync_adv` and `line_end` are 0. A reset in the middle of a line also restarts the line at position 0.
- R2: From the start of a line (position 0), the subgroup counter counts 3 to 15 while the group counter holds 3. That is 13 positions, so `col_addr` goes 51 to 63.
- R3: After the first pass, every subgroup pass counts 0 to 15. The group counter steps by one on the edge where the subgroup counter wraps from 15 to 0.
- R4: The terminal state is group = 9 and subgroup = 8 (position 101). On the next edge both counters reload 3, so position 0 follows with `col_addr` = 51.
- R5: Rising `line_end` pulses come exactly 102 clock cycles apart.
- R6: `hsync_adv` equals group bit 3. It is high for positions 77 to 101 and low otherwise.
- R7: `hdisp` equals group bit 2. It is high for positions 13 to 76, which are 64 positions, and low otherwise.
- R8: `col_addr[3:0]` is the subgroup count and `col_addr[5:4]` is group bits 1:0. So `col_addr` is p+51 for p<13, p−13 for 13≤p≤76, and p−77 for p≥77.
- R9: `line_end` is high for exactly one cycle per line, during the terminal position 101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character-time clock |
| rst | input | 1 | Synchronous reset, active high; loads 3 into both counters |
| col_addr | output | 6 | Display RAM column address {group[1:0], subgroup} |
| hdisp | output | 1 | Display window of the line (group bit 2) |
| hsync_adv | output | 1 | Horizontal sync advance (group bit 3) |
| line_end | output | 1 | One-cycle terminal pulse for the scan line counter |

## Verification
The only input besides the clock is `rst`, and the assertions assume it is held for at least one rising edge. Each reset therefore loads a defined state before any check on the counters is made. The stimulus always holds reset for a full edge, including the reset given in the middle of a line. Reset is changed one time unit after a rising edge, so every counter path runs freely from the reload state between resets.

// File: rtl/hchar_pkg.sv
package hchar_pkg;

  // Number of character times in one line, for a counter pair that reloads
  // pre_v, where the subgroup counter has 2**w states and the line ends at
  // (term_g, term_s).
  function automatic int line_length(input int w, input int pre_v,
                                     input int term_g, input int term_s);
    int span;
    span = 1 << w;
    return (span - pre_v) + (term_g - pre_v - 1) * span + (term_s + 1);
  endfunction

  // Column address: the low group bits sit above the subgroup bits.
  function automatic logic [5:0] pack_col(input logic [3:0] grp,
                                          input logic [3:0] sub);
    return {grp[1:0], sub};
  endfunction

endpackage

// File: rtl/hchar_ctr.sv
module hchar_ctr #(
  parameter int W        = 4,
  parameter int LOAD_VAL = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         en,
  output logic [W-1:0] q,
  output logic         carry
);
  localparam logic [W-1:0] LoadV = W'(LOAD_VAL);

  always_ff @(posedge clk) begin
    if (rst || load) q <= LoadV;
    else if (en)     q <= q + 1'b1;
  end

  assign carry = en && (q == {W{1'b1}});
endmodule

// File: rtl/hchar_term_decode.sv
module hchar_term_decode #(
  parameter int W      = 4,
  parameter int TERM_G = 9,
  parameter int TERM_S = 8
) (
  input  logic [W-1:0] grp,
  input  logic [W-1:0] sub,
  output logic         hit
);
  assign hit = (grp == W'(TERM_G)) && (sub == W'(TERM_S));
endmodule

// File: rtl/hchar_timing.sv
module hchar_timing #(
  parameter int W        = 4,
  parameter int PRELOAD  = 3,
  parameter int TERM_G   = 9,
  parameter int TERM_S   = 8
) (
  input  logic       clk,
  input  logic       rst,
  output logic [5:0] col_addr,
  output logic       hdisp,
  output logic       hsync_adv,
  output logic       line_end
);
  localparam int LineLen = hchar_pkg::line_length(W, PRELOAD, TERM_G, TERM_S);

  // Named internal events, visible to the bound checker.
  logic [W-1:0] sub_q;
  logic [W-1:0] grp_q;
  logic         sub_wrap;
  logic         grp_carry;
  logic         term_hit;

  hchar_ctr #(.W(W), .LOAD_VAL(PRELOAD)) u_sub (
    .clk(clk), .rst(rst), .load(term_hit), .en(1'b1),
    .q(sub_q), .carry(sub_wrap)
  );

  hchar_ctr #(.W(W), .LOAD_VAL(PRELOAD)) u_grp (
    .clk(clk), .rst(rst), .load(term_hit), .en(sub_wrap),
    .q(grp_q), .carry(grp_carry)
  );

  hchar_term_decode #(.W(W), .TERM_G(TERM_G), .TERM_S(TERM_S)) u_term (
    .grp(grp_q), .sub(sub_q), .hit(term_hit)
  );

  assign col_addr  = hchar_pkg::pack_col(grp_q[3:0], sub_q[3:0]);
  assign hdisp     = grp_q[2];
  assign hsync_adv = grp_q[3];
  assign line_end  = term_hit;
endmodule

// File: rtl/hchar_timing_chk.sv
module hchar_timing_chk #(
  parameter int W       = 4,
  parameter int PRELOAD = 3,
  parameter int LINELEN = 102
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] sub_q,
  input logic [W-1:0] grp_q,
  input logic         term_hit,
  input logic [5:0]   col_addr,
  input logic         hdisp,
  input logic         hsync_adv,
  input logic         line_end
);
  logic [15:0] since_start;

  always_ff @(posedge clk) begin
    if (rst || line_end) since_start <= '0;
    else                 since_start <= since_start + 1'b1;
  end

  // R4: terminal state reloads both counters
  a_r4_reload: assert property (@(posedge clk) disable iff (rst)
    term_hit |=> (sub_q == W'(PRELOAD)) && (grp_q == W'(PRELOAD)));

  // R3: subgroup wrap steps the group counter
  a_r3_group_step: assert property (@(posedge clk) disable iff (rst)
    (!term_hit && sub_q == {W{1'b1}}) |=>
      (sub_q == '0) && (grp_q == $past(grp_q) + 1'b1));

  // R3: within a pass the group holds and the subgroup counts up
  a_r3_sub_step: assert property (@(posedge clk) disable iff (rst)
    (!term_hit && sub_q != {W{1'b1}}) |=>
      (sub_q == $past(sub_q) + 1'b1) && $stable(grp_q));

  // R2: during the first group the subgroup never sits below the preload
  a_r2_first_pass: assert property (@(posedge clk) disable iff (rst)
    (grp_q == W'(PRELOAD)) |-> (sub_q >= W'(PRELOAD)));

  // R9: the end pulse lasts one cycle
  a_r9_single: assert property (@(posedge clk) disable iff (rst)
    line_end |=> !line_end);

  // R5: line period
  a_r5_period: assert property (@(posedge clk) disable iff (rst)
    line_end |-> (since_start == 16'(LINELEN - 1)));

  // R7: the display window opens at column 0
  a_r7_window_start: assert property (@(posedge clk) disable iff (rst)
    $rose(hdisp) |-> (col_addr == 6'd0) && !hsync_adv);

  // R6: the sync advance starts when the display window closes
  a_r6_adv_start: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync_adv) |-> $fell(hdisp) && (col_addr == 6'd0));
endmodule

bind hchar_timing hchar_timing_chk #(.W(W), .PRELOAD(PRELOAD), .LINELEN(LineLen)) u_chk (
  .clk(clk), .rst(rst), .sub_q(sub_q), .grp_q(grp_q), .term_hit(term_hit),
  .col_addr(col_addr), .hdisp(hdisp), .hsync_adv(hsync_adv), .line_end(line_end)
);

// File: tb/test_hchar_timing.sv
`timescale 1ns/1ps
module test_hchar_timing;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] col_addr;
  logic       hdisp, hsync_adv, line_end;

  int errors = 0;
  int checks = 0;
  int pos    = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  hchar_timing i_hchar_timing (
    .clk(clk), .rst(rst), .col_addr(col_addr),
    .hdisp(hdisp), .hsync_adv(hsync_adv), .line_end(line_end)
  );

  // Vector: [15:9] position, [8:3] col, [2] hdisp, [1] hsync_adv, [0] line_end
  localparam logic [15:0] VEC [10] = '{
    {7'd0,   6'd51, 3'b000},
    {7'd12,  6'd63, 3'b000},
    {7'd13,  6'd0,  3'b100},
    {7'd28,  6'd15, 3'b100},
    {7'd29,  6'd16, 3'b100},
    {7'd76,  6'd63, 3'b100},
    {7'd77,  6'd0,  3'b010},
    {7'd93,  6'd16, 3'b010},
    {7'd100, 6'd23, 3'b010},
    {7'd101, 6'd24, 3'b011}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s pos=%0d actual=%0d expected=%0d", req, pos, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    pos = (pos + 1) % 102;
  endtask

  // Expected values restated from R6..R9 by line position.
  function automatic int exp_col(input int p);
    if (p < 13)      return p + 51;
    else if (p < 77) return p - 13;
    else             return p - 77;
  endfunction

  initial begin
    // R1: reset state
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 col", col_addr, 51);
    check("R1 hdisp", hdisp, 0);
    check("R1 adv", hsync_adv, 0);
    check("R1 end", line_end, 0);
    rst = 1'b0;
    pos = 0;

    // Table walk over one line
    for (int i = 0; i < 10; i++) begin
      while (pos != int'(VEC[i][15:9])) step();
      check("R8 col", col_addr, int'(VEC[i][8:3]));
      check("R7 hdisp", hdisp, int'(VEC[i][2]));
      check("R6 adv", hsync_adv, int'(VEC[i][1]));
      check("R9 end", line_end, int'(VEC[i][0]));
    end

    // R4: wrap after terminal
    step();
    check("R4 reload col", col_addr, 51);
    check("R4 reload end", line_end, 0);

    // Two full lines against the position model; R5 period
    begin
      int cyc = 0;
      int last_end = -1;
      for (int n = 0; n < 204; n++) begin
        check(pos < 13 ? "R2 col" : "R3 col", col_addr, exp_col(pos));
        check("R7 hdisp", hdisp, (pos >= 13 && pos <= 76) ? 1 : 0);
        check("R6 adv", hsync_adv, (pos >= 77) ? 1 : 0);
        check("R9 end", line_end, (pos == 101) ? 1 : 0);
        if (line_end) begin
          if (last_end >= 0) check("R5 period", cyc - last_end, 102);
          last_end = cyc;
        end
        step();
        cyc++;
      end
    end

    // R1: reset in mid line
    while (pos != 40) step();
    check("R1 pre-reset col", col_addr, 27);
    rst = 1'b1;
    @(posedge clk);
    #1;
    rst = 1'b0;
    pos = 0;
    check("R1 mid-line reset col", col_addr, 51);
    check("R1 mid-line reset hdisp", hdisp, 0);
    step();
    check("R2 after reset col", col_addr, 52);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog pos=%0d actual=timeout expected=done", pos);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule